// File: doc/BRIEF.md
# Ring-Checked Parallel TLB Lookup

This block translates a virtual address by searching every way of a small set-associative translation buffer in the same cycle. Each way has a fixed page size. The index of an entry within a way is the two address bits just above that way's page offset. Each entry holds a page-aligned virtual tag, a page-aligned physical base, an 8-bit address-space identifier and a 4-bit attribute.

A matching entry counts only if its identifier is nonzero and appears in one of the four byte lanes of a packed ring-identifier register. The lane number becomes the entry's protection ring, and that ring is compared with the privilege level of the request. The attribute then decides read, write and execute permission and a cache mode. A single result register reports a cause code, and on success it also reports the physical address, the page size and the cache mode, one cycle after the request.

Software or a walker outside the block fills entries through two ports. The explicit write port names a way and an index. The refill port takes a virtual address and a page-table word, and it rotates over the small-page ways.

Top module: `ring_tlb`

## Requirements
- R1: A request sampled with `reqValid` high at a clock edge produces `rspValid` high after that edge, and the result holds until the next edge. Without a request, `rspValid` is low after the edge.
- R2: After reset the ring-identifier register holds 0x04030201, with lane 0 in bits [7:0]. Every entry has identifier 0 except four entries that all carry identifier 1. Way 5 maps 0xD0000000 to physical 0 with attribute 7, and 0xD8000000 to physical 0 with attribute 3. Way 6 maps 0xE0000000 to 0xF0000000 with attribute 7, and 0xF0000000 to 0xF0000000 with attribute 3.
- R3: Ways 0 to 3 use 4 KiB pages, way 4 uses 1 MiB pages, way 5 uses 128 MiB pages and way 6 uses 256 MiB pages. A way hits when all of the following hold: the indexed entry's tag equals the request address with its page-offset bits cleared, the entry's identifier is nonzero, and that identifier equals some lane of the ring register. The ring is the lowest matching lane number.
- R4: When no way hits, the cause is 1 for a fetch and 5 for a load or store.
- R5: When two or more ways hit, the cause is 2 for a fetch and 6 for a load or store, whatever the ring and the attribute are.
- R6: With exactly one hit whose ring is numerically below `reqPriv`, the cause is 3 for a fetch and 7 for a load or store.
- R7: `reqKind` 0 is a load, 1 is a store, and 2 or 3 is a fetch. An attribute below 12 gives read, plus execute if bit 0 is set and write if bit 1 is set. Attribute 13 gives read and write. Every other attribute gives nothing. A fetch needs execute, a load needs read and a store needs write; the other rights do not count. Denials give cause 4 for a fetch, 8 for a load and 9 for a store.
- R8: On success the cause is 0. The physical address is the entry base ORed with the request's page-offset bits, and the page size is the way's page size in bytes. The cache mode comes from attribute bits [3:2]: 0 is bypass (code 0), 1 is write-back (code 1) and 2 is write-through (code 2). Attribute 13 gives isolate (code 3). On any fault, the address, page size and cache mode are all 0.
- R9: The write port stores the tag and base with their page-offset bits cleared, together with the identifier and attribute, at (`wrWay`, `wrIdx`). The new contents affect only requests sampled at later edges; a request in the same cycle sees the old contents.
- R10: A refill writes a 4 KiB entry in one of ways 0 to 3. The index comes from `refillVaddr` bits [13:12], the tag from `refillVaddr` and the base from `refillPte` bits [31:12]. The identifier is the ring-register lane selected by `refillPte` bits [5:4], and the attribute is `refillPte` bits [3:0]. The target way rotates 1, 2, 3, 0, 1 and so on, starting from reset. If `wrEn` is high in the same cycle, the refill is dropped and the rotation does not advance.
- R11: `rasidWrEn` loads all four lanes from `rasidIn` at the edge. Lookups sampled after that edge use the new lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup request strobe |
| reqVaddr | input | 32 | Virtual address to translate |
| reqKind | input | 2 | 0 load, 1 store, 2 or 3 fetch |
| reqPriv | input | 2 | Requester privilege index |
| wrEn | input | 1 | Explicit entry write strobe |
| wrWay | input | 3 | Way to write |
| wrIdx | input | 2 | Entry index within the way |
| wrVpn | input | 32 | Virtual tag (offset bits dropped) |
| wrPpn | input | 32 | Physical base (offset bits dropped) |
| wrAsid | input | 8 | Identifier, 0 marks the entry invalid |
| wrAttr | input | 4 | Attribute code |
| refillEn | input | 1 | Refill strobe |
| refillVaddr | input | 32 | Address being refilled |
| refillPte | input | 32 | Page-table word for the refill |
| rasidWrEn | input | 1 | Ring-register load strobe |
| rasidIn | input | 32 | New ring-register value, lane 0 low |
| rspValid | output | 1 | Result valid |
| rspCause | output | 4 | Result cause code, 0 on success |
| rspPaddr | output | 32 | Physical address on success |
| rspPageSize | output | 32 | Page size in bytes on success |
| rspCache | output | 2 | Cache mode on success |

## Verification
The bench first looks up the four entries present after reset, from several privilege levels, and an address that no entry maps. This separates correct reset contents from wrong ones and checks the offset splicing for the two large page sizes. It then loads all 16 attribute codes against all four request kinds in one small-page entry. That sweep separates the read, write and execute decode from the side masking and the three denial codes. Next, it moves an entry's identifier through every ring lane and every privilege, and also tries identifiers that are zero or found in no lane, to separate ring order and validity. Duplicate tags in two ways, a chain of refills with an invalidation after each, a refill that collides with a write, and a write that lands in the same cycle as a lookup show the multi-hit precedence, the rotation order and the update timing.

// File: rtl/ring_tlb_pkg.sv
package ring_tlb_pkg;
  localparam int ADDR_W   = 32;
  localparam int ASID_W   = 8;
  localparam int ATTR_W   = 4;
  localparam int RING_N   = 4;
  localparam int RING_W   = $clog2(RING_N);
  localparam int CAUSE_W  = 4;
  localparam int PTE_RING_LSB = 4;
  localparam int FIX_WAY_LO = 5;
  localparam int FIX_WAY_HI = 6;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_OK      = 4'd0,
    CAUSE_I_MISS  = 4'd1,
    CAUSE_I_MULTI = 4'd2,
    CAUSE_I_PRIV  = 4'd3,
    CAUSE_I_DENY  = 4'd4,
    CAUSE_D_MISS  = 4'd5,
    CAUSE_D_MULTI = 4'd6,
    CAUSE_D_PRIV  = 4'd7,
    CAUSE_LD_DENY = 4'd8,
    CAUSE_ST_DENY = 4'd9
  } cause_e;

  typedef enum logic [1:0] {
    CM_BYPASS  = 2'd0,
    CM_WBACK   = 2'd1,
    CM_WTHRU   = 2'd2,
    CM_ISOLATE = 2'd3
  } cache_e;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;

  typedef struct packed {
    logic [ADDR_W-1:0] vpn;
    logic [ADDR_W-1:0] ppn;
    logic [ASID_W-1:0] asid;
    logic [ATTR_W-1:0] attr;
  } entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic entryWr;
    logic fromRefill;
    logic rasidWr;
    logic rspLoad;
  } strobe_t;

  function automatic int wayShift(input int w);
    if (w < 4)       return 12;
    else if (w == 4) return 20;
    else if (w == 5) return 27;
    else             return 28;
  endfunction

  function automatic logic [ADDR_W-1:0] wayMask(input int w);
    return ~((ADDR_W'(1) << wayShift(w)) - ADDR_W'(1));
  endfunction

  function automatic logic [ASID_W*RING_N-1:0] rasidInit();
    logic [ASID_W*RING_N-1:0] r;
    r = '0;
    for (int l = 0; l < RING_N; l++) r[l*ASID_W +: ASID_W] = ASID_W'(l + 1);
    return r;
  endfunction

  function automatic entry_t resetEntry(input int w, input int i, input int idxW);
    entry_t e;
    logic [ADDR_W-1:0] va;
    logic [ADDR_W-1:0] idxMask;
    e = '0;
    idxMask = (ADDR_W'(1) << idxW) - ADDR_W'(1);
    if (w == FIX_WAY_LO || w == FIX_WAY_HI) begin
      for (int k = 0; k < 2; k++) begin
        if (w == FIX_WAY_LO) va = (k == 0) ? 32'hD000_0000 : 32'hD800_0000;
        else                 va = (k == 0) ? 32'hE000_0000 : 32'hF000_0000;
        if (((va >> wayShift(w)) & idxMask) == ADDR_W'(i)) begin
          e.vpn  = va;
          e.ppn  = (w == FIX_WAY_LO) ? '0 : 32'hF000_0000;
          e.asid = ASID_W'(1);
          e.attr = (k == 0) ? ATTR_W'(7) : ATTR_W'(3);
        end
      end
    end
    return e;
  endfunction
endpackage

// File: rtl/tlb_attr_decode.sv
module tlb_attr_decode
  import ring_tlb_pkg::*;
(
  input  logic [ATTR_W-1:0] attr,
  output logic              canRead,
  output logic              canWrite,
  output logic              canExec,
  output cache_e            cacheMode
);
  logic normalAttr;
  logic isoAttr;

  assign normalAttr = (attr < ATTR_W'(12));
  assign isoAttr    = (attr == ATTR_W'(13));

  assign canRead  = normalAttr || isoAttr;
  assign canWrite = (normalAttr && attr[1]) || isoAttr;
  assign canExec  = normalAttr && attr[0];

  always_comb begin
    if (isoAttr)         cacheMode = CM_ISOLATE;
    else begin
      unique case (attr[3:2])
        2'd1:    cacheMode = CM_WBACK;
        2'd2:    cacheMode = CM_WTHRU;
        default: cacheMode = CM_BYPASS;
      endcase
    end
  end
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import ring_tlb_pkg::*;
#(
  parameter int NUM_WAYS    = 7,
  parameter int REFILL_WAYS = 4,
  localparam int RW_W       = $clog2(REFILL_WAYS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqKind,
  input  logic [RING_W-1:0]   reqPriv,
  input  logic                wrEn,
  input  logic                refillEn,
  input  logic                rasidWrEn,
  input  logic [NUM_WAYS-1:0] hitVec,
  input  logic [RING_W-1:0]   selRing,
  input  logic [ATTR_W-1:0]   selAttr,
  output strobe_t             stb,
  output logic [RW_W-1:0]     refillWay,
  output cause_e              nextCause,
  output cache_e              nextCache
);
  logic [RW_W-1:0] lastWay;
  logic            refillTake;
  logic            anyHit;
  logic            multiHit;
  logic            isFetch;
  logic            canRead;
  logic            canWrite;
  logic            canExec;
  logic            granted;

  assign refillTake = refillEn && !wrEn;
  assign refillWay  = (lastWay == RW_W'(REFILL_WAYS - 1)) ? '0 : lastWay + RW_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lastWay <= '0;
    else if (refillTake) lastWay <= refillWay;
  end

  always_comb begin
    stb.entryWr    = wrEn || refillEn;
    stb.fromRefill = refillTake;
    stb.rasidWr    = rasidWrEn;
    stb.rspLoad    = reqValid;
  end

  tlb_attr_decode u_attr (
    .attr     (selAttr),
    .canRead  (canRead),
    .canWrite (canWrite),
    .canExec  (canExec),
    .cacheMode(nextCache)
  );

  assign isFetch  = reqKind[1];
  assign anyHit   = |hitVec;
  assign multiHit = |(hitVec & (hitVec - NUM_WAYS'(1)));

  always_comb begin
    if (isFetch)                   granted = canExec;
    else if (reqKind == KIND_LOAD) granted = canRead;
    else                           granted = canWrite;
  end

  always_comb begin
    if (!anyHit)                nextCause = isFetch ? CAUSE_I_MISS : CAUSE_D_MISS;
    else if (multiHit)          nextCause = isFetch ? CAUSE_I_MULTI : CAUSE_D_MULTI;
    else if (selRing < reqPriv) nextCause = isFetch ? CAUSE_I_PRIV : CAUSE_D_PRIV;
    else if (!granted) begin
      if (isFetch)                   nextCause = CAUSE_I_DENY;
      else if (reqKind == KIND_LOAD) nextCause = CAUSE_LD_DENY;
      else                           nextCause = CAUSE_ST_DENY;
    end
    else                        nextCause = CAUSE_OK;
  end
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import ring_tlb_pkg::*;
#(
  parameter int NUM_WAYS    = 7,
  parameter int IDX_W       = 2,
  parameter int REFILL_WAYS = 4,
  localparam int WAY_W      = $clog2(NUM_WAYS),
  localparam int ENTRIES    = 1 << IDX_W,
  localparam int RW_W       = $clog2(REFILL_WAYS),
  localparam int RASID_W    = ASID_W * RING_N
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [ADDR_W-1:0]   reqVaddr,
  input  logic [WAY_W-1:0]    wrWay,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [ADDR_W-1:0]   wrVpn,
  input  logic [ADDR_W-1:0]   wrPpn,
  input  logic [ASID_W-1:0]   wrAsid,
  input  logic [ATTR_W-1:0]   wrAttr,
  input  logic [ADDR_W-1:0]   refillVaddr,
  input  logic [ADDR_W-1:0]   refillPte,
  input  logic [RW_W-1:0]     refillWay,
  input  logic [RASID_W-1:0]  rasidIn,
  input  cause_e              nextCause,
  input  cache_e              nextCache,
  output logic [NUM_WAYS-1:0] hitVec,
  output logic [RING_W-1:0]   selRing,
  output logic [ATTR_W-1:0]   selAttr,
  output logic                rspValid,
  output cause_e              rspCause,
  output logic [ADDR_W-1:0]   rspPaddr,
  output logic [ADDR_W-1:0]   rspPageSize,
  output cache_e              rspCache
);
  logic [RASID_W-1:0] rasid;
  logic [ASID_W-1:0]  refillAsid;
  logic [ADDR_W-1:0]  wayPpn  [NUM_WAYS];
  logic [ADDR_W-1:0]  wayMsk  [NUM_WAYS];
  logic [ATTR_W-1:0]  wayAttr [NUM_WAYS];
  logic [RING_W-1:0]  wayRing [NUM_WAYS];
  logic [ADDR_W-1:0]  selPpn;
  logic [ADDR_W-1:0]  selMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rasid <= rasidInit();
    else if (stb.rasidWr) rasid <= rasidIn;
  end

  assign refillAsid = rasid[refillPte[PTE_RING_LSB +: RING_W]*ASID_W +: ASID_W];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    localparam int SHIFT = wayShift(w);
    localparam logic [ADDR_W-1:0] MASK = wayMask(w);
    entry_t           mem [ENTRIES];
    entry_t           cur;
    logic [IDX_W-1:0] lkIdx;
    logic [IDX_W-1:0] rfIdx;
    logic             wrHere;
    logic             rfHere;
    logic             laneFound;
    logic [RING_W-1:0] laneRing;

    assign lkIdx  = reqVaddr[SHIFT +: IDX_W];
    assign rfIdx  = refillVaddr[SHIFT +: IDX_W];
    assign wrHere = stb.entryWr && !stb.fromRefill && (wrWay == WAY_W'(w));

    if (w < REFILL_WAYS) begin : g_rf
      assign rfHere = stb.entryWr && stb.fromRefill && (refillWay == RW_W'(w));
    end else begin : g_norf
      assign rfHere = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < ENTRIES; i++) mem[i] <= resetEntry(w, i, IDX_W);
      end else if (wrHere) begin
        mem[wrIdx] <= '{vpn: wrVpn & MASK, ppn: wrPpn & MASK, asid: wrAsid, attr: wrAttr};
      end else if (rfHere) begin
        mem[rfIdx] <= '{vpn: refillVaddr & MASK, ppn: refillPte & MASK,
                        asid: refillAsid, attr: refillPte[ATTR_W-1:0]};
      end
    end

    assign cur = mem[lkIdx];

    always_comb begin
      laneFound = 1'b0;
      laneRing  = '0;
      for (int l = RING_N - 1; l >= 0; l--) begin
        if (rasid[l*ASID_W +: ASID_W] == cur.asid) begin
          laneFound = 1'b1;
          laneRing  = RING_W'(l);
        end
      end
    end

    assign hitVec[w]  = (cur.asid != '0) && laneFound && ((reqVaddr & MASK) == cur.vpn);
    assign wayPpn[w]  = cur.ppn;
    assign wayMsk[w]  = MASK;
    assign wayAttr[w] = cur.attr;
    assign wayRing[w] = laneRing;
  end

  always_comb begin
    selPpn  = '0;
    selMask = '0;
    selAttr = '0;
    selRing = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hitVec[w]) begin
        selPpn  = selPpn  | wayPpn[w];
        selMask = selMask | wayMsk[w];
        selAttr = selAttr | wayAttr[w];
        selRing = selRing | wayRing[w];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspCause    <= CAUSE_OK;
      rspPaddr    <= '0;
      rspPageSize <= '0;
      rspCache    <= CM_BYPASS;
    end else begin
      rspValid <= stb.rspLoad;
      if (stb.rspLoad) begin
        rspCause <= nextCause;
        if (nextCause == CAUSE_OK) begin
          rspPaddr    <= selPpn | (reqVaddr & ~selMask);
          rspPageSize <= ~selMask + ADDR_W'(1);
          rspCache    <= nextCache;
        end else begin
          rspPaddr    <= '0;
          rspPageSize <= '0;
          rspCache    <= CM_BYPASS;
        end
      end
    end
  end
endmodule

// File: rtl/ring_tlb.sv
module ring_tlb
  import ring_tlb_pkg::*;
#(
  parameter int NUM_WAYS    = 7,
  parameter int IDX_W       = 2,
  parameter int REFILL_WAYS = 4,
  localparam int WAY_W      = $clog2(NUM_WAYS),
  localparam int RW_W       = $clog2(REFILL_WAYS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [ADDR_W-1:0]         reqVaddr,
  input  logic [1:0]                reqKind,
  input  logic [RING_W-1:0]         reqPriv,
  input  logic                      wrEn,
  input  logic [WAY_W-1:0]          wrWay,
  input  logic [IDX_W-1:0]          wrIdx,
  input  logic [ADDR_W-1:0]         wrVpn,
  input  logic [ADDR_W-1:0]         wrPpn,
  input  logic [ASID_W-1:0]         wrAsid,
  input  logic [ATTR_W-1:0]         wrAttr,
  input  logic                      refillEn,
  input  logic [ADDR_W-1:0]         refillVaddr,
  input  logic [ADDR_W-1:0]         refillPte,
  input  logic                      rasidWrEn,
  input  logic [ASID_W*RING_N-1:0]  rasidIn,
  output logic                      rspValid,
  output logic [CAUSE_W-1:0]        rspCause,
  output logic [ADDR_W-1:0]         rspPaddr,
  output logic [ADDR_W-1:0]         rspPageSize,
  output logic [1:0]                rspCache
);
  strobe_t             stb;
  logic [RW_W-1:0]     refillWay;
  cause_e              nextCause;
  cache_e              nextCache;
  logic [NUM_WAYS-1:0] hitVec;
  logic [RING_W-1:0]   selRing;
  logic [ATTR_W-1:0]   selAttr;
  cause_e              causeQ;
  cache_e              cacheQ;

  tlb_ctrl #(.NUM_WAYS(NUM_WAYS), .REFILL_WAYS(REFILL_WAYS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .reqPriv  (reqPriv),
    .wrEn     (wrEn),
    .refillEn (refillEn),
    .rasidWrEn(rasidWrEn),
    .hitVec   (hitVec),
    .selRing  (selRing),
    .selAttr  (selAttr),
    .stb      (stb),
    .refillWay(refillWay),
    .nextCause(nextCause),
    .nextCache(nextCache)
  );

  tlb_datapath #(.NUM_WAYS(NUM_WAYS), .IDX_W(IDX_W), .REFILL_WAYS(REFILL_WAYS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqVaddr   (reqVaddr),
    .wrWay      (wrWay),
    .wrIdx      (wrIdx),
    .wrVpn      (wrVpn),
    .wrPpn      (wrPpn),
    .wrAsid     (wrAsid),
    .wrAttr     (wrAttr),
    .refillVaddr(refillVaddr),
    .refillPte  (refillPte),
    .refillWay  (refillWay),
    .rasidIn    (rasidIn),
    .nextCause  (nextCause),
    .nextCache  (nextCache),
    .hitVec     (hitVec),
    .selRing    (selRing),
    .selAttr    (selAttr),
    .rspValid   (rspValid),
    .rspCause   (causeQ),
    .rspPaddr   (rspPaddr),
    .rspPageSize(rspPageSize),
    .rspCache   (cacheQ)
  );

  assign rspCause = causeQ;
  assign rspCache = cacheQ;
endmodule

// File: rtl/ring_tlb_chk.sv
module ring_tlb_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] reqVaddr,
  input logic        rspValid,
  input logic [3:0]  rspCause,
  input logic [31:0] rspPaddr,
  input logic [31:0] rspPageSize,
  input logic [1:0]  rspCache
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R1

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R1

  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCause != 4'd0) |-> (rspPaddr == 32'd0 && rspPageSize == 32'd0 && rspCache == 2'd0)); // R8

  AST_PAGE_POW2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCause == 4'd0) |-> ($countones(rspPageSize) == 1)); // R8

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid ##1 (rspValid && rspCause == 4'd0)) |->
      (((rspPaddr ^ $past(reqVaddr)) & (rspPageSize - 32'd1)) == 32'd0)); // R8

  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspCause <= 4'd9)); // R4
endmodule

bind ring_tlb ring_tlb_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqVaddr   (reqVaddr),
  .rspValid   (rspValid),
  .rspCause   (rspCause),
  .rspPaddr   (rspPaddr),
  .rspPageSize(rspPageSize),
  .rspCache   (rspCache)
);

// File: tb/ring_tlb_tb.sv
module ring_tlb_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqKind = '0;
  logic [1:0]  reqPriv = '0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrWay = '0;
  logic [1:0]  wrIdx = '0;
  logic [31:0] wrVpn = '0;
  logic [31:0] wrPpn = '0;
  logic [7:0]  wrAsid = '0;
  logic [3:0]  wrAttr = '0;
  logic        refillEn = 1'b0;
  logic [31:0] refillVaddr = '0;
  logic [31:0] refillPte = '0;
  logic        rasidWrEn = 1'b0;
  logic [31:0] rasidIn = '0;
  logic        rspValid;
  logic [3:0]  rspCause;
  logic [31:0] rspPaddr;
  logic [31:0] rspPageSize;
  logic [1:0]  rspCache;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  ring_tlb u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] priv);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqKind = kind; reqPriv = priv;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectRsp(input string tag, input logic [31:0] va, input logic [1:0] kind,
                           input logic [1:0] priv, input logic [3:0] cause,
                           input logic [31:0] pa, input logic [31:0] sz, input logic [1:0] cm);
    lookup(va, kind, priv);
    chk({tag, " valid"}, {31'd0, rspValid}, 32'd1);
    chk({tag, " cause"}, {28'd0, rspCause}, {28'd0, cause});
    chk({tag, " paddr"}, rspPaddr, pa);
    chk({tag, " size"}, rspPageSize, sz);
    chk({tag, " cache"}, {30'd0, rspCache}, {30'd0, cm});
  endtask

  task automatic expectCause(input string tag, input logic [31:0] va, input logic [1:0] kind,
                             input logic [1:0] priv, input logic [3:0] cause);
    lookup(va, kind, priv);
    chk({tag, " cause"}, {28'd0, rspCause}, {28'd0, cause});
  endtask

  task automatic writeEntry(input logic [2:0] way, input logic [1:0] idx, input logic [31:0] vpn,
                            input logic [31:0] ppn, input logic [7:0] asid, input logic [3:0] attr);
    @(negedge clk);
    wrEn = 1'b1; wrWay = way; wrIdx = idx; wrVpn = vpn; wrPpn = ppn; wrAsid = asid; wrAttr = attr;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRefill(input logic [31:0] va, input logic [31:0] pte);
    @(negedge clk);
    refillEn = 1'b1; refillVaddr = va; refillPte = pte;
    @(negedge clk);
    refillEn = 1'b0;
  endtask

  task automatic setRasid(input logic [31:0] v);
    @(negedge clk);
    rasidWrEn = 1'b1; rasidIn = v;
    @(negedge clk);
    rasidWrEn = 1'b0;
  endtask

  function automatic logic [3:0] permCause(input int a, input int kind);
    bit rd, wr, ex;
    rd = (a < 12) || (a == 13);
    wr = ((a < 12) && ((a & 2) != 0)) || (a == 13);
    ex = (a < 12) && ((a & 1) != 0);
    if (kind >= 2) return ex ? 4'd0 : 4'd4;
    if (kind == 0) return rd ? 4'd0 : 4'd8;
    return wr ? 4'd0 : 4'd9;
  endfunction

  function automatic logic [1:0] cacheOf(input int a);
    if (a == 13) return 2'd3;
    return 2'((a >> 2) & 3);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'd0, rspValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {31'd0, rspValid}, 32'd0);

    // R2: fixed entries after reset, ring register 0x04030201
    expectRsp("R2 way5 lo fetch", 32'hD000_1234, 2'd2, 2'd0, 4'd0, 32'h0000_1234, 32'h0800_0000, 2'd1);
    expectRsp("R2 way5 hi store", 32'hD800_0010, 2'd1, 2'd0, 4'd0, 32'h0000_0010, 32'h0800_0000, 2'd0);
    expectRsp("R2 way6 lo load",  32'hE000_0040, 2'd0, 2'd0, 4'd0, 32'hF000_0040, 32'h1000_0000, 2'd1);
    expectRsp("R2 way6 hi fetch", 32'hF123_4567, 2'd3, 2'd0, 4'd0, 32'hF123_4567, 32'h1000_0000, 2'd0);
    expectRsp("R4 miss load", 32'h0000_1000, 2'd0, 2'd0, 4'd5, 32'd0, 32'd0, 2'd0);
    expectCause("R4 miss fetch", 32'h0000_1000, 2'd2, 2'd0, 4'd1);
    expectCause("R6 fetch priv1", 32'hD000_1234, 2'd2, 2'd1, 4'd3);
    expectRsp("R6 load priv2", 32'hD000_1234, 2'd0, 2'd2, 4'd7, 32'd0, 32'd0, 2'd0);

    // R7 R8: attribute sweep in a 4 KiB entry, ring 0
    for (int a = 0; a < 16; a++) begin
      writeEntry(3'd0, 2'd1, 32'h0000_5000, 32'h1234_5000, 8'd1, 4'(a));
      for (int k = 0; k < 4; k++) begin
        logic [3:0] c;
        c = permCause(a, k);
        expectRsp($sformatf("R7 attr%0d kind%0d", a, k), 32'h0000_5ABC, 2'(k), 2'd0, c,
                  (c == 0) ? 32'h1234_5ABC : 32'd0, (c == 0) ? 32'h0000_1000 : 32'd0,
                  (c == 0) ? cacheOf(a) : 2'd0);
      end
    end

    // R11: new ring lanes; fixed entries (identifier 1) no longer hit
    setRasid(32'h4030_2010);
    expectCause("R11 old id gone", 32'hD000_1234, 2'd2, 2'd0, 4'd1);

    // R3 R6: ring lanes against privilege
    for (int l = 0; l < 4; l++) begin
      writeEntry(3'd0, 2'd2, 32'h0000_6000, 32'h00AB_C000, 8'((l + 1) * 16), 4'd7);
      for (int p = 0; p < 4; p++) begin
        if (l < p)
          expectRsp($sformatf("R6 lane%0d priv%0d", l, p), 32'h0000_6654, 2'd0, 2'(p), 4'd7, 32'd0, 32'd0, 2'd0);
        else
          expectRsp($sformatf("R3 lane%0d priv%0d", l, p), 32'h0000_6654, 2'd0, 2'(p), 4'd0,
                    32'h00AB_C654, 32'h0000_1000, 2'd1);
      end
    end
    writeEntry(3'd0, 2'd2, 32'h0000_6000, 32'h00AB_C000, 8'h55, 4'd7);
    expectCause("R3 id not in lanes", 32'h0000_6654, 2'd0, 2'd0, 4'd5);
    writeEntry(3'd0, 2'd2, 32'h0000_6000, 32'h00AB_C000, 8'h00, 4'd7);
    expectCause("R3 id zero", 32'h0000_6654, 2'd0, 2'd0, 4'd5);

    // R3 R8: 1 MiB way and tag compare
    writeEntry(3'd4, 2'd3, 32'h1230_0000, 32'hABC0_0000, 8'h10, 4'd7);
    expectRsp("R8 way4 1MiB", 32'h123F_0F0F, 2'd0, 2'd0, 4'd0, 32'hABCF_0F0F, 32'h0010_0000, 2'd1);
    expectCause("R3 tag mismatch", 32'h127F_0F0F, 2'd0, 2'd0, 4'd5);

    // R5: duplicate tags in two ways
    writeEntry(3'd0, 2'd3, 32'h0000_7000, 32'h0011_1000, 8'h10, 4'd7);
    writeEntry(3'd1, 2'd3, 32'h0000_7000, 32'h0022_2000, 8'h20, 4'd7);
    expectRsp("R5 multi load", 32'h0000_7ABC, 2'd0, 2'd0, 4'd6, 32'd0, 32'd0, 2'd0);
    expectCause("R5 multi fetch", 32'h0000_7ABC, 2'd2, 2'd0, 4'd2);
    expectCause("R5 multi over priv", 32'h0000_7ABC, 2'd0, 2'd3, 4'd6);
    writeEntry(3'd1, 2'd3, 32'h0000_7000, 32'h0022_2000, 8'h00, 4'd7);
    expectRsp("R9 invalidate one", 32'h0000_7ABC, 2'd0, 2'd0, 4'd0, 32'h0011_1ABC, 32'h0000_1000, 2'd1);

    // R10: refill rotation 1,2,3,0 with ring field 2 -> identifier 0x30
    doRefill(32'h0000_9000, 32'h7777_7027);
    expectRsp("R10 refill hit", 32'h0000_9123, 2'd0, 2'd2, 4'd0, 32'h7777_7123, 32'h0000_1000, 2'd1);
    expectCause("R10 refill ring2", 32'h0000_9123, 2'd0, 2'd3, 4'd7);
    doRefill(32'h0000_9000, 32'h7777_7027);
    expectCause("R10 second way", 32'h0000_9123, 2'd0, 2'd0, 4'd6);
    writeEntry(3'd1, 2'd1, 32'h0, 32'h0, 8'h00, 4'd0);
    expectCause("R10 first was way1", 32'h0000_9123, 2'd0, 2'd0, 4'd0);
    writeEntry(3'd2, 2'd1, 32'h0, 32'h0, 8'h00, 4'd0);
    expectCause("R10 second was way2", 32'h0000_9123, 2'd0, 2'd0, 4'd5);
    doRefill(32'h0000_9000, 32'h7777_7027);
    expectCause("R10 third hit", 32'h0000_9123, 2'd0, 2'd0, 4'd0);
    writeEntry(3'd3, 2'd1, 32'h0, 32'h0, 8'h00, 4'd0);
    expectCause("R10 third was way3", 32'h0000_9123, 2'd0, 2'd0, 4'd5);
    doRefill(32'h0000_9000, 32'h7777_7027);
    expectCause("R10 fourth hit", 32'h0000_9123, 2'd0, 2'd0, 4'd0);
    writeEntry(3'd0, 2'd1, 32'h0, 32'h0, 8'h00, 4'd0);
    expectCause("R10 fourth was way0", 32'h0000_9123, 2'd0, 2'd0, 4'd5);

    // R10: refill colliding with an explicit write is dropped
    @(negedge clk);
    wrEn = 1'b1; wrWay = 3'd4; wrIdx = 2'd0; wrVpn = 32'h0; wrPpn = 32'h0; wrAsid = 8'h00; wrAttr = 4'd0;
    refillEn = 1'b1; refillVaddr = 32'h0000_9000; refillPte = 32'h7777_7027;
    @(negedge clk);
    wrEn = 1'b0; refillEn = 1'b0;
    expectCause("R10 dropped refill", 32'h0000_9123, 2'd0, 2'd0, 4'd5);
    doRefill(32'h0000_9000, 32'h7777_7027);
    writeEntry(3'd1, 2'd1, 32'h0, 32'h0, 8'h00, 4'd0);
    expectCause("R10 no advance on drop", 32'h0000_9123, 2'd0, 2'd0, 4'd5);

    // R9: write and lookup in the same cycle; offset bits of the tag dropped
    @(negedge clk);
    wrEn = 1'b1; wrWay = 3'd0; wrIdx = 2'd3; wrVpn = 32'h0000_B123; wrPpn = 32'h0022_2FFF;
    wrAsid = 8'h10; wrAttr = 4'd7;
    reqValid = 1'b1; reqVaddr = 32'h0000_B456; reqKind = 2'd0; reqPriv = 2'd0;
    @(negedge clk);
    wrEn = 1'b0; reqValid = 1'b0;
    chk("R9 same cycle old", {28'd0, rspCause}, 32'd5);
    expectRsp("R9 next cycle new", 32'h0000_B456, 2'd0, 2'd0, 4'd0, 32'h0022_2456, 32'h0000_1000, 2'd1);

    repeat (2) @(negedge clk);
    chk("R1 idle low", {31'd0, rspValid}, 32'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule